// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block takes 28 asynchronous interrupt pins and turns each one into a latched pending flag. Each pin has its own trigger detector, which can be set for a low level, a high level, a falling edge, a rising edge or both edges. The trigger code is programmed in 3-bit fields, and the two inputs of a pair share one field. Pending flags that are not masked are OR-reduced into four group request lines, which feed a main interrupt controller.

Software uses a small register port. Two configuration words hold the trigger fields. The mask register has one bit per input; a set bit blocks that input from its group. The pending register reads back the latched flags and is cleared by writing ones. The group sizes are unequal: the first group covers four inputs and the other three cover eight each.

Top module: `ext_irq_grp`

## Requirements
- R1: After reset, pending reads 0, mask reads 0x0FFFFFFF (every input masked), both configuration words read 0, and every group output is low. The input synchronisers reset to the high (inactive) state.
- R2: Register addresses are 0 for the first trigger word, 1 for the second trigger word, 2 for mask and 3 for pending. Inputs 2p and 2p+1 share pair p. The field for pair p sits in word p/8 at bits [4*(p%8)+2 : 4*(p%8)]. For example, inputs 10 and 11 use bits 22:20 of word 0, and inputs 16 and 17 use bits 2:0 of word 1.
- R3: Trigger code 000 means low level and 001 means high level. A level trigger sets the pending bit on every cycle the level holds, so a write-one clear made while the level persists leaves the bit set.
- R4: Trigger codes 010 and 011 mean falling edge. The pending bit is set once per high-to-low transition, and it stays clear after a clear while the pin is steady.
- R5: Trigger codes 100 and 101 mean rising edge. The pending bit is set once per low-to-high transition.
- R6: Trigger codes 110 and 111 mean both edges. The pending bit is set once per transition in either direction.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R8: If a trigger event and a write-one clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: A set mask bit keeps its input off the group output, but the pending bit still latches. Clearing the mask bit of a pending input raises its group output at once.
- R10: grp_o[0] covers inputs 0–3, grp_o[1] covers 4–11, grp_o[2] covers 12–19 and grp_o[3] covers 20–27. Each group output is the OR of the pending-and-unmasked bits in its range.
- R11: A pin change is visible in pending after the third rising clock edge that follows it (two synchroniser stages plus the pending register). It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 28 | Asynchronous interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data (combinational on addr_i) |
| grp_o | output | 4 | Group interrupt requests |

## Verification
The assertions assume that reset is asserted from time zero. They also treat the detector's event vector as the only legitimate source of a newly set pending bit, which holds only if software never writes the pending register with anything but a clear. The stimulus holds every pin high through reset. It drives pins and register writes only at falling clock edges. After each change of trigger code it clears pending before it judges detector behaviour, so events caused by the reconfiguration itself never leak into a later check.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

  typedef enum logic [2:0] {
    DET_LOW,
    DET_HIGH,
    DET_FALL,
    DET_RISE,
    DET_BOTH
  } det_e;

  localparam int unsigned TRIG_W = 3;
  localparam int unsigned SLOT_W = 4;

  // 000 low, 001 high, 01x fall, 10x rise, 11x both
  function automatic det_e decode_trig(input logic [TRIG_W-1:0] f);
    det_e d;
    unique case (f[2:1])
      2'b00:   d = f[0] ? DET_HIGH : DET_LOW;
      2'b01:   d = DET_FALL;
      2'b10:   d = DET_RISE;
      default: d = DET_BOTH;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
`timescale 1ns/1ps
module ext_irq_sync #(
  parameter int unsigned N       = 28,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= RST_VAL;
        s2_q   <= RST_VAL;
        prev_q <= RST_VAL;
      end else begin
        s1_q   <= pin_i[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign lvl_o[i]  = s2_q;
    assign prev_o[i] = prev_q;
  end

endmodule

// File: rtl/ext_irq_detect.sv
`timescale 1ns/1ps
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned N = 28
) (
  input  logic [N-1:0]             lvl_i,
  input  logic [N-1:0]             prev_i,
  input  logic [N-1:0][TRIG_W-1:0] trig_i,
  output logic [N-1:0]             evt_o
);

  for (genvar i = 0; i < N; i++) begin : g_det
    always_comb begin
      unique case (decode_trig(trig_i[i]))
        DET_LOW:  evt_o[i] = ~lvl_i[i];
        DET_HIGH: evt_o[i] = lvl_i[i];
        DET_FALL: evt_o[i] = prev_i[i] & ~lvl_i[i];
        DET_RISE: evt_o[i] = ~prev_i[i] & lvl_i[i];
        default:  evt_o[i] = prev_i[i] ^ lvl_i[i];
      endcase
    end
  end

endmodule

// File: rtl/ext_irq_regs.sv
`timescale 1ns/1ps
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned N      = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [N-1:0]             evt_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [N-1:0][TRIG_W-1:0] trig_o,
  output logic [N-1:0]             mask_o,
  output logic [N-1:0]             pend_o
);

  localparam int unsigned N_PAIRS   = (N + 1) / 2;
  localparam int unsigned SLOTS     = DATA_W / SLOT_W;
  localparam int unsigned N_CFG     = (N_PAIRS + SLOTS - 1) / SLOTS;
  localparam int unsigned ADDR_MASK = N_CFG;
  localparam int unsigned ADDR_PEND = N_CFG + 1;

  logic [N_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [N-1:0]                 mask_q, pend_q, clr;

  assign clr = (wr_en_i && addr_i == ADDR_W'(ADDR_PEND)) ? wr_data_i[N-1:0] : '0;

  for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   cfg_q[k] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(k))      cfg_q[k] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wr_data_i[N-1:0];
      // new event outranks a simultaneous clear
      pend_q <= (pend_q & ~clr) | evt_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_fld
    localparam int unsigned P = i / 2;
    localparam int unsigned W = P / SLOTS;
    localparam int unsigned S = P % SLOTS;
    assign trig_o[i] = cfg_q[W][S*SLOT_W +: TRIG_W];
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_CFG; k++)
      if (addr_i == ADDR_W'(k)) rd_data_o = cfg_q[k];
    if (addr_i == ADDR_W'(ADDR_MASK)) rd_data_o = DATA_W'(mask_q);
    if (addr_i == ADDR_W'(ADDR_PEND)) rd_data_o = DATA_W'(pend_q);
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/ext_irq_grp.sv
`timescale 1ns/1ps
module ext_irq_grp
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IN    = 28,
  parameter int unsigned FIRST_W = 4,
  parameter int unsigned GRP_W   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned N_GRP   = 1 + (N_IN - FIRST_W) / GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_GRP-1:0]  grp_o
);

  logic [N_IN-1:0]             lvl, prev, evt, mask_q, pend_q, act;
  logic [N_IN-1:0][TRIG_W-1:0] trig;

  ext_irq_sync #(.N(N_IN), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  ext_irq_detect #(.N(N_IN)) u_det (
    .lvl_i  (lvl),
    .prev_i (prev),
    .trig_i (trig),
    .evt_o  (evt)
  );

  ext_irq_regs #(.N(N_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .evt_i     (evt),
    .rd_data_o (rd_data_o),
    .trig_o    (trig),
    .mask_o    (mask_q),
    .pend_o    (pend_q)
  );

  assign act = pend_q & ~mask_q;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int unsigned LO = (g == 0) ? 0 : FIRST_W + (g - 1) * GRP_W;
    localparam int unsigned HI = (g == 0) ? FIRST_W - 1 : LO + GRP_W - 1;
    assign grp_o[g] = |act[HI:LO];
  end

endmodule

// File: rtl/ext_irq_grp_chk.sv
`timescale 1ns/1ps
module ext_irq_grp_chk #(
  parameter int unsigned N_IN   = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned N_GRP  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [N_GRP-1:0]  grp_o,
  input logic [N_IN-1:0]   evt_i,
  input logic [N_IN-1:0]   pend_i,
  input logic [N_IN-1:0]   mask_i
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(3);

  logic [N_IN-1:0] clr_v;
  assign clr_v = (wr_en_i && addr_i == A_PEND) ? wr_data_i[N_IN-1:0] : '0;

  // R8: a bit only becomes pending through a detector event
  a_r8_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & ~$past(pend_i) & ~$past(evt_i)) == '0));

  // R7: a cleared bit with no concurrent event reads zero
  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_i & $past(clr_v) & ~$past(evt_i)) == '0));

  // R9: pending holds until cleared
  a_r9_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_i) & ~$past(clr_v) & ~pend_i) == '0));

  // R10: fully masked block raises no group
  a_r10_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> (grp_o == '0));

  // R9: a group output never rises with nothing pending
  a_r9_grp_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_o != '0) |-> (pend_i != '0));

endmodule

bind ext_irq_grp ext_irq_grp_chk #(
  .N_IN(N_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_GRP(N_GRP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .grp_o     (grp_o),
  .evt_i     (evt),
  .pend_i    (pend_q),
  .mask_i    (mask_q)
);

// File: tb/ext_irq_grp_bench.sv
`timescale 1ns/1ps
module ext_irq_grp_bench;

  localparam int N = 28;
  localparam logic [31:0] ALL = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pin = '1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  grp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ext_irq_grp u_ext_irq_grp (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .grp_o(grp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int grp_of(input int i);
    return (i < 4) ? 0 : 1 + (i - 4) / 8;
  endfunction

  task automatic set_trig(input int i, input logic [2:0] code);
    int p = i / 2;
    logic [31:0] w = 32'(code) << (4 * (p % 8));
    wr(2'd0, (p / 8 == 0) ? w : 32'h0);
    wr(2'd1, (p / 8 == 1) ? w : 32'h0);
  endtask

  task automatic sweep_one(input int i, input logic [2:0] code);
    logic [31:0] v, bi, bp, gexp;
    bit is_low, is_high, is_fall, is_rise, is_both;
    bi = 32'h1 << i;
    bp = 32'h1 << (i ^ 1);
    gexp = 32'h1 << grp_of(i);
    is_low  = (code == 3'b000);
    is_high = (code == 3'b001);
    is_fall = (code[2:1] == 2'b01);
    is_rise = (code[2:1] == 2'b10);
    is_both = (code[2:1] == 2'b11);
    set_trig(i, code);
    wr(2'd2, ALL & ~bi);
    wait_cyc(4);
    if (is_high) begin
      rd(2'd3, v); chk("R2 R3 high level sets pair", v, bi | bp);
      chk("R10 group of input", {28'h0, grp}, gexp);
      pin[i] = 1'b0;
      wait_cyc(4);
      wr(2'd3, ALL);
      rd(2'd3, v); chk("R3 clear after level gone, partner re-set", v, bp);
      chk("R9 masked partner off group", {28'h0, grp}, 32'h0);
    end else begin
      rd(2'd3, v); chk("R4 R5 R6 no event while steady", v, 32'h0);
      pin[i] = 1'b0;
      wait_cyc(4);
      rd(2'd3, v); chk("R3 R4 R6 falling/low response", v, (is_low | is_fall | is_both) ? bi : 32'h0);
      chk("R10 group tracks input", {28'h0, grp}, (is_low | is_fall | is_both) ? gexp : 32'h0);
      wr(2'd3, bi);
      rd(2'd3, v); chk("R3 R4 clear while low", v, is_low ? bi : 32'h0);
      pin[i] = 1'b1;
      wait_cyc(4);
      rd(2'd3, v); chk("R3 R5 R6 rising response", v, (is_low | is_rise | is_both) ? bi : 32'h0);
      wr(2'd3, bi);
      rd(2'd3, v); chk("R7 clear with pin steady", v, 32'h0);
    end
    pin = '1;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd2, ALL);
    wait_cyc(4);
    wr(2'd3, ALL);
  endtask

  initial begin
    logic [31:0] v;
    logic [2:0] codes [5];
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b011;
    codes[3] = 3'b100; codes[4] = 3'b111;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    rd(2'd0, v); chk("R1 cfg0 reset", v, 32'h0);
    rd(2'd1, v); chk("R1 cfg1 reset", v, 32'h0);
    rd(2'd2, v); chk("R1 mask reset", v, ALL);
    rd(2'd3, v); chk("R1 pend reset", v, 32'h0);
    chk("R1 groups reset", {28'h0, grp}, 32'h0);

    for (int i = 0; i < N; i++)
      for (int m = 0; m < 5; m++)
        sweep_one(i, codes[m]);

    // R11 latency on input 7, rising
    set_trig(7, 3'b100);
    pin[7] = 1'b0;
    wait_cyc(4);
    wr(2'd3, ALL);
    pin[7] = 1'b1;
    wait_cyc(2);
    rd(2'd3, v); chk("R11 not yet after two edges", v, 32'h0);
    wait_cyc(1);
    rd(2'd3, v); chk("R11 set after third edge", v, 32'h80);

    // R8 collision on input 7, both edges; bit already set
    set_trig(7, 3'b110);
    pin[7] = 1'b0;
    wait_cyc(2);
    wr_en = 1'b1; addr = 2'd3; wdata = 32'h80;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd3, v); chk("R8 event wins over clear", v, 32'h80);
    pin[7] = 1'b1;
    wait_cyc(3);
    wr_en = 1'b1; addr = 2'd3; wdata = 32'h80;
    @(negedge clk);
    wr_en = 1'b0;
    rd(2'd3, v); chk("R8 clear one cycle after event", v, 32'h0);

    // R9 masked latch, unmask raises group; R7 zero writes
    set_trig(5, 3'b100);
    wr(2'd2, ALL);
    pin[5] = 1'b0;
    wait_cyc(4);
    wr(2'd3, ALL);
    pin[5] = 1'b1;
    wait_cyc(4);
    rd(2'd3, v); chk("R9 pending latches while masked", v, 32'h20);
    chk("R9 masked group low", {28'h0, grp}, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R7 zero write no effect", v, 32'h20);
    wr(2'd3, ALL & ~32'h20);
    rd(2'd3, v); chk("R7 other ones leave bit", v, 32'h20);
    wr(2'd2, ALL & ~32'h20);
    rd(2'd2, v); chk("R2 mask readback", v, ALL & ~32'h20);
    #1 chk("R9 unmask raises group", {28'h0, grp}, 32'h2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule